// File: doc/BRIEF.md
# DMA and Interrupt Request Router

This block sits between a two-channel serial controller and a system bus. It holds one 8-bit read/write routing register. That register decides which of the controller's three request pins drives the bus transmit DMA request and which drives the bus receive DMA request. It also decides which of three event sources drives the bus interrupt line. The three events are a latched DMA terminal count, the controller's own interrupt, and a test-mode input.

A strap input selects how the interrupt line is driven. In shared-line mode the line's output enable is raised only while an interrupt is active, so several boards can share one wire. In dedicated mode the line is always driven. The terminal-count source is only usable in shared-line mode. Every output is registered, so an output reflects the inputs and the register contents present at the previous clock edge.

Top module: `dma_irq_router`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), the register reads 0x00 and drq_tx, drq_rx, irq_out, irq_oe and route_conflict are all 0.
- R2: A write stores bits 5..0 of the write data. Bits 7..6 always read back as 0, and the other bits read back as written.
- R3: Bit 0 picks the transmit source. A value of 1 selects the channel A DTR/request pin and 0 selects the channel A wait/request pin. drq_tx follows the selected pin.
- R4: Bit 1 picks the receive source. A value of 1 selects the channel B wait/request pin and 0 selects the channel A wait/request pin. drq_rx follows the selected pin.
- R5: Bit 2 enables transmit and bit 3 enables receive. While an enable bit is 0, that direction's DRQ stays at 0 whatever the request pins do.
- R6: Bits 3..0 equal to 1100 is illegal, because one pin would feed both DRQs. In that case drq_rx is held at 0 and route_conflict is 1. drq_tx still follows the channel A wait/request pin.
- R7: Bits 5..4 select the interrupt source. 00 turns the interrupt off, 01 selects terminal count, 10 selects the controller interrupt and 11 selects the test-mode input.
- R8: With select 01 in shared-line mode, a pulse on tc_pulse sets a flag that drives irq_out until the next register write clears it. If a pulse and a write fall in the same cycle, the flag is set.
- R9: In dedicated mode (share_mode=0) the terminal-count source never raises irq_out, and pulses seen in that mode are not remembered.
- R10: In shared-line mode irq_oe equals irq_out. In dedicated mode irq_oe is 1.
- R11: Every output changes one clock edge after the input or register value that causes it. The terminal-count flag adds one further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| req_a_wait | input | 1 | Channel A wait/request pin |
| req_a_dtr | input | 1 | Channel A DTR/request pin |
| req_b_wait | input | 1 | Channel B wait/request pin |
| tc_pulse | input | 1 | DMA terminal-count pulse |
| test_mode_in | input | 1 | Test-mode indication |
| ctrl_irq | input | 1 | Serial controller interrupt |
| share_mode | input | 1 | Strap: 1 for shared-line interrupt, 0 for dedicated |
| drq_tx | output | 1 | Bus transmit DMA request |
| drq_rx | output | 1 | Bus receive DMA request |
| irq_out | output | 1 | Bus interrupt level |
| irq_oe | output | 1 | Bus interrupt output enable |
| route_conflict | output | 1 | Illegal routing combination present |

## Verification
A terminal-count pulse sets the interrupt flag, and a register write clears it, so the two can land on the same edge. The bench drives tc_pulse and a register write in the same cycle with terminal-count select active. It expects irq_out to be 1 two edges later and to stay 1 until a following write alone clears it. The illegal routing code is also applied while channel A wait/request is high. The bench expects drq_tx to be 1, drq_rx to be 0 and route_conflict to be 1 in the same sampled cycle.

// File: rtl/router_pkg.sv
package router_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_TC   = 2'b01,
    IRQ_CTRL = 2'b10,
    IRQ_TEST = 2'b11
  } irq_sel_e;

  // packed order matches register bits 5..0
  typedef struct packed {
    irq_sel_e irq_sel;
    logic     rx_en;
    logic     tx_en;
    logic     rx_from_b;
    logic     tx_from_dtr;
  } route_cfg_t;

  localparam int CFG_USED_W = $bits(route_cfg_t);
endpackage

// File: rtl/route_cfg_reg.sv
module route_cfg_reg
  import router_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output route_cfg_t       cfg,
  output logic [REG_W-1:0] rdata
);
  localparam int PAD_W = REG_W - CFG_USED_W;

  logic unused_hi;
  assign unused_hi = ^wdata[REG_W-1:CFG_USED_W];

  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= route_cfg_t'(wdata[CFG_USED_W-1:0]);
  end

  assign rdata = {{PAD_W{1'b0}}, cfg};
endmodule

// File: rtl/drq_steer.sv
module drq_steer #(
  parameter int N_DIR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DIR-1:0] en,
  input  logic [N_DIR-1:0] pick_alt,
  input  logic [N_DIR-1:0] src_main,
  input  logic [N_DIR-1:0] src_alt,
  input  logic [N_DIR-1:0] block,
  output logic [N_DIR-1:0] drq
);
  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic pick;
    assign pick = pick_alt[d] ? src_alt[d] : src_main[d];
    always_ff @(posedge clk) begin
      if (rst) drq[d] <= 1'b0;
      else     drq[d] <= en[d] & ~block[d] & pick;
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import router_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_sel_e sel,
  input  logic     share,
  input  logic     tc_pulse,
  input  logic     cfg_write,
  input  logic     ctrl_irq,
  input  logic     test_mode,
  output logic     irq_out,
  output logic     irq_oe
);
  logic tc_flag;
  logic active;

  // a pulse wins over a write-clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                                   tc_flag <= 1'b0;
    else if (tc_pulse && share && sel == IRQ_TC) tc_flag <= 1'b1;
    else if (cfg_write)                        tc_flag <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      IRQ_TC:   active = tc_flag & share;
      IRQ_CTRL: active = ctrl_irq;
      IRQ_TEST: active = test_mode;
      default:  active = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      irq_oe  <= 1'b0;
    end else begin
      irq_out <= active;
      irq_oe  <= share ? active : 1'b1;
    end
  end
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import router_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             req_a_wait,
  input  logic             req_a_dtr,
  input  logic             req_b_wait,
  input  logic             tc_pulse,
  input  logic             test_mode_in,
  input  logic             ctrl_irq,
  input  logic             share_mode,
  output logic             drq_tx,
  output logic             drq_rx,
  output logic             irq_out,
  output logic             irq_oe,
  output logic             route_conflict
);
  localparam int TX = 0;
  localparam int RX = 1;

  route_cfg_t cfg;
  logic [1:0] drq;
  logic       illegal;

  route_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  assign illegal = cfg.tx_en & cfg.rx_en & ~cfg.tx_from_dtr & ~cfg.rx_from_b;

  drq_steer #(.N_DIR(2)) u_drq (
    .clk(clk), .rst(rst),
    .en      ({cfg.rx_en,     cfg.tx_en}),
    .pick_alt({cfg.rx_from_b, cfg.tx_from_dtr}),
    .src_main({req_a_wait,    req_a_wait}),
    .src_alt ({req_b_wait,    req_a_dtr}),
    .block   ({illegal,       1'b0}),
    .drq     (drq)
  );

  assign drq_tx = drq[TX];
  assign drq_rx = drq[RX];

  always_ff @(posedge clk) begin
    if (rst) route_conflict <= 1'b0;
    else     route_conflict <= illegal;
  end

  irq_select u_irq (
    .clk(clk), .rst(rst), .sel(cfg.irq_sel), .share(share_mode),
    .tc_pulse(tc_pulse), .cfg_write(cfg_we), .ctrl_irq(ctrl_irq),
    .test_mode(test_mode_in), .irq_out(irq_out), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/router_checker.sv
module router_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_rdata,
  input logic       share_mode,
  input logic       drq_tx,
  input logic       drq_rx,
  input logic       irq_out,
  input logic       irq_oe,
  input logic       route_conflict
);
  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[2] |=> !drq_tx); // R5
  AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[3] |=> !drq_rx); // R5
  AST_CONFLICT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[3:0] == 4'b1100) |=> (route_conflict && !drq_rx)); // R6
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[5:4] == 2'b00) |=> !irq_out); // R7
  AST_SHARE_OE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(share_mode)) |-> (irq_oe == irq_out)); // R10
  AST_DEDICATED_OE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(share_mode)) |-> irq_oe); // R10
endmodule

bind dma_irq_router router_checker u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .share_mode(share_mode),
  .drq_tx(drq_tx), .drq_rx(drq_rx), .irq_out(irq_out), .irq_oe(irq_oe),
  .route_conflict(route_conflict)
);

// File: tb/dma_irq_router_test.sv
`timescale 1ns/1ps
module dma_irq_router_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       req_a_wait = 1'b0, req_a_dtr = 1'b0, req_b_wait = 1'b0;
  logic       tc_pulse = 1'b0, test_mode_in = 1'b0, ctrl_irq = 1'b0;
  logic       share_mode = 1'b1;
  logic       drq_tx, drq_rx, irq_out, irq_oe, route_conflict;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  dma_irq_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_a_wait(req_a_wait), .req_a_dtr(req_a_dtr),
    .req_b_wait(req_b_wait), .tc_pulse(tc_pulse), .test_mode_in(test_mode_in),
    .ctrl_irq(ctrl_irq), .share_mode(share_mode), .drq_tx(drq_tx),
    .drq_rx(drq_rx), .irq_out(irq_out), .irq_oe(irq_oe),
    .route_conflict(route_conflict)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 drq", {drq_tx, drq_rx}, 8'h0);
    check("R1 irq", {irq_out, irq_oe}, 8'h0);
    check("R1 conflict", route_conflict, 8'h0);
  endtask

  task automatic t_readback();
    write_cfg(8'hFF);
    check("R2 high bits zero", cfg_rdata, 8'h3F);
    write_cfg(8'h2A);
    check("R2 readback", cfg_rdata, 8'h2A);
    write_cfg(8'h00); step();
  endtask

  task automatic t_tx_source();
    req_a_dtr = 1'b1; req_a_wait = 1'b0;
    write_cfg(8'h05);
    check("R11 drq before edge", drq_tx, 8'h0);
    step();
    check("R3 dtr selected", drq_tx, 8'h1);
    req_a_dtr = 1'b0; req_a_wait = 1'b1; step();
    check("R3 wait ignored", drq_tx, 8'h0);
    write_cfg(8'h04); step();
    check("R3 wait selected", drq_tx, 8'h1);
    req_a_wait = 1'b0; step();
    check("R3 follows pin", drq_tx, 8'h0);
  endtask

  task automatic t_rx_source();
    req_b_wait = 1'b1; req_a_wait = 1'b0;
    write_cfg(8'h0A); step();
    check("R4 chB selected", drq_rx, 8'h1);
    req_b_wait = 1'b0; req_a_wait = 1'b1; step();
    check("R4 chA ignored", drq_rx, 8'h0);
    write_cfg(8'h08); step();
    check("R4 chA selected", drq_rx, 8'h1);
    req_a_wait = 1'b0;
  endtask

  task automatic t_enables();
    req_a_wait = 1'b1; req_a_dtr = 1'b1; req_b_wait = 1'b1;
    write_cfg(8'h03); step(); step();
    check("R5 both disabled", {drq_tx, drq_rx}, 8'h0);
    write_cfg(8'h0F); step();
    check("R5 both enabled", {drq_tx, drq_rx}, 8'h3);
    req_a_wait = 1'b0; req_a_dtr = 1'b0; req_b_wait = 1'b0;
  endtask

  task automatic t_conflict();
    req_a_wait = 1'b1;
    write_cfg(8'h0C); step();
    check("R6 tx follows wait", drq_tx, 8'h1);
    check("R6 rx blocked", drq_rx, 8'h0);
    check("R6 conflict flag", route_conflict, 8'h1);
    write_cfg(8'h0D); step();
    check("R6 conflict cleared", route_conflict, 8'h0);
    check("R6 rx restored", drq_rx, 8'h1);
    req_a_wait = 1'b0;
  endtask

  task automatic t_irq_select();
    share_mode = 1'b0;
    ctrl_irq = 1'b1;
    write_cfg(8'h20); step();
    check("R7 ctrl source", {irq_out, irq_oe}, 8'h3);
    ctrl_irq = 1'b0; test_mode_in = 1'b1; step();
    check("R7 test ignored on ctrl", irq_out, 8'h0);
    write_cfg(8'h30); step();
    check("R7 test source", irq_out, 8'h1);
    ctrl_irq = 1'b1;
    write_cfg(8'h00); step();
    check("R7 disabled", irq_out, 8'h0);
    check("R10 dedicated oe", irq_oe, 8'h1);
    ctrl_irq = 1'b0; test_mode_in = 1'b0;
  endtask

  task automatic t_tc_latch();
    share_mode = 1'b1;
    write_cfg(8'h10); step();
    check("R8 idle", irq_out, 8'h0);
    tc_pulse = 1'b1; step(); tc_pulse = 1'b0;
    check("R11 flag delay", irq_out, 8'h0);
    step();
    check("R8 set by pulse", {irq_out, irq_oe}, 8'h3);
    step(); step();
    check("R8 held", irq_out, 8'h1);
    write_cfg(8'h10); step();
    check("R8 cleared by write", irq_out, 8'h0);
    tc_pulse = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h10;
    step();
    tc_pulse = 1'b0; cfg_we = 1'b0;
    step();
    check("R8 pulse wins over write", irq_out, 8'h1);
    write_cfg(8'h10); step();
    check("R8 cleared after collision", irq_out, 8'h0);
  endtask

  task automatic t_tc_dedicated();
    share_mode = 1'b0;
    write_cfg(8'h10); step();
    tc_pulse = 1'b1; step(); tc_pulse = 1'b0; step(); step();
    check("R9 no tc irq dedicated", {irq_out, irq_oe}, 8'h1);
    share_mode = 1'b1; step(); step();
    check("R9 pulse not remembered", irq_out, 8'h0);
  endtask

  task automatic t_share();
    share_mode = 1'b1;
    write_cfg(8'h20); step();
    check("R10 oe off idle", irq_oe, 8'h0);
    ctrl_irq = 1'b1; step();
    check("R10 oe on active", {irq_out, irq_oe}, 8'h3);
    ctrl_irq = 1'b0; step();
    check("R10 oe released", irq_oe, 8'h0);
  endtask

  initial begin
    step(); step(); step();
    t_reset();
    rst = 1'b0;
    step();
    t_readback();
    t_tx_source();
    t_rx_source();
    t_enables();
    t_conflict();
    t_irq_select();
    t_tc_latch();
    t_tc_dedicated();
    t_share();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule